// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block handles the lock-bit commands of a flash memory's command interface. It accepts bus write cycles, each a command byte plus the block-select bits of the address. It keeps one lock bit per block and a single master lock bit. A set block lock bit stops program and erase of that block. The master lock bit only controls whether the block lock bits may be changed. Once the master bit is set, changes to block lock bits need the high-voltage override flag on the reset pin.

Each lock change takes two writes: a setup command, then a confirm command. After a valid confirm, a busy counter of `BUSY_CYC` cycles stands in for the internal operation. The ready output is low for that period, and all writes are ignored. At the end of the period the lock state changes, or sticky error bits are raised in the status byte. While a lock operation is pending or finished, reads return the status byte (`status_mode` high) until a new mode command is written.

The controller is built around four states:
- ST_ARRAY: read-array mode.
- ST_STATUS: read-status mode.
- ST_SETUP: a setup command has been written and a confirm is awaited.
- ST_BUSY: the timed operation is running.

Transitions:
- ST_ARRAY/ST_STATUS → ST_SETUP on `0x60`.
- ST_ARRAY/ST_STATUS → ST_STATUS on `0x70`.
- ST_ARRAY/ST_STATUS → ST_ARRAY on `0xFF`.
- `0x50` clears the error bits without changing state.
- ST_SETUP → ST_BUSY on a valid confirm (`0x01`, `0xF1` or `0xD0`).
- ST_SETUP → ST_STATUS on any other byte (invalid confirm).
- ST_BUSY → ST_STATUS when the counter expires.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset the block is in read-array mode (`status_mode`=0), `ready`=1, `status`=0x80, and all lock bits and the master bit are 0.
- R2: Setup `0x60` followed by confirm `0x01` sets the lock bit of the block chosen by `wr_blk` on the confirm write. With the master bit clear, the override is not needed and the status ends as 0x80 (or 0x80 plus any errors already held).
- R3: After a valid confirm, `ready` and status bit 7 stay 0 for exactly `BUSY_CYC` cycles. Lock state stays unchanged until the cycle they return to 1.
- R4: Writes made while busy are ignored: they change neither the mode, the error bits, nor the result of the running operation.
- R5: Confirm `0xF1` sets the master bit only when `hv_ovr`=1. Otherwise status bits 1 and 4 are set and the master bit stays 0.
- R6: With the master bit set and `hv_ovr`=0, a block set fails with status bits 1 and 4 and no lock change. With `hv_ovr`=1 it succeeds.
- R7: Confirm `0xD0` clears all block lock bits at once. With the master bit set and `hv_ovr`=0 it fails with status bits 1 and 5 and no change.
- R8: With `vpp_ok`=0 at completion, nothing changes. A clear sets status bits 3 and 5; a block or master set sets status bits 3 and 4.
- R9: A byte other than `0x01`, `0xF1` or `0xD0` after setup sets status bits 4 and 5, starts no busy period, changes no lock bit, and enters read-status mode.
- R10: Once set, the master bit is never cleared by any command.
- R11: Error bits 1, 3, 4 and 5 are sticky. Only `0x50`, written outside the busy period, clears them. Lock commands still run normally while they are set.
- R12: `0x70` selects read-status mode and `0xFF` selects read-array mode. Setup and completed lock operations leave the block in read-status mode. `0x50` does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_cmd | input | 8 | Command byte of the write |
| wr_blk | input | $clog2(NBLK) | Top address bits selecting a block |
| hv_ovr | input | 1 | High-voltage override present on the reset pin |
| vpp_ok | input | 1 | Programming voltage valid |
| ready | output | 1 | 1 when no lock operation is running |
| status_mode | output | 1 | 1 when reads return the status byte |
| status | output | 8 | Status byte: bit 7 ready, bits 5/4/3/1 sticky errors |
| lock_vec | output | NBLK | Per-block lock bits, gating program and erase |
| master_lock | output | 1 | Master lock bit |

## Verification
Mode changes and invalid-confirm errors appear one cycle after the write edge. Lock bits and completion errors appear exactly `BUSY_CYC` cycles after the confirm edge. The driver issues each write on a falling edge and counts whole cycles from the confirm before pushing each expected item. It pushes items at three points:
- just after the confirm, expecting busy;
- one cycle before completion, expecting still busy;
- just after completion, expecting the result.

The monitor compares every item at that falling edge, so each result is sampled half a cycle after the edge that produced it.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_SETUP,
        ST_BUSY
    } lk_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_SET_BLK,
        OP_SET_MST,
        OP_CLR
    } lk_op_e;

    typedef struct packed {
        logic clr;   // status bit 5
        logic set;   // status bit 4
        logic vpp;   // status bit 3
        logic prot;  // status bit 1
    } lk_err_t;

    localparam logic [7:0] CMD_SETUP    = 8'h60;
    localparam logic [7:0] CMD_CF_BLK   = 8'h01;
    localparam logic [7:0] CMD_CF_MST   = 8'hF1;
    localparam logic [7:0] CMD_CF_CLR   = 8'hD0;
    localparam logic [7:0] CMD_CLR_STAT = 8'h50;
    localparam logic [7:0] CMD_RD_STAT  = 8'h70;
    localparam logic [7:0] CMD_RD_ARR   = 8'hFF;

endpackage

// File: rtl/lock_busy_timer.sv
module lock_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Last busy cycle: counter about to reach zero
    assign done = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/lock_bit_store.sv
module lock_bit_store
    import flash_lock_pkg::*;
#(
    parameter int NBLK = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    apply,
    input  lk_op_e                  op,
    input  logic [$clog2(NBLK)-1:0] blk,
    input  logic                    hv_ovr,
    input  logic                    vpp_ok,
    output lk_err_t                 err,
    output logic [NBLK-1:0]         lock_vec,
    output logic                    master_lock
);
    localparam int BLK_W = $clog2(NBLK);

    logic [NBLK-1:0] lock_q;
    logic [NBLK-1:0] blk_hit;
    logic            mst_q;
    logic            ok;

    // Outcome of the pending operation, judged on current state and flags
    always_comb begin
        err = '0;
        if (!vpp_ok) begin
            err.vpp = 1'b1;
            if (op == OP_CLR) err.clr = 1'b1;
            else              err.set = 1'b1;
        end else begin
            unique case (op)
                OP_SET_BLK: if (mst_q && !hv_ovr) begin
                    err.prot = 1'b1;
                    err.set  = 1'b1;
                end
                OP_SET_MST: if (!hv_ovr) begin
                    err.prot = 1'b1;
                    err.set  = 1'b1;
                end
                OP_CLR: if (mst_q && !hv_ovr) begin
                    err.prot = 1'b1;
                    err.clr  = 1'b1;
                end
                OP_NONE: ;
            endcase
        end
    end

    assign ok = (err == '0);

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        assign blk_hit[b] = (blk == BLK_W'(b));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lock_q[b] <= 1'b0;
            end else if (apply && ok) begin
                if (op == OP_CLR)
                    lock_q[b] <= 1'b0;
                else if (op == OP_SET_BLK && blk_hit[b])
                    lock_q[b] <= 1'b1;
            end
        end
    end

    // Master bit: only ever set, no path clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q <= 1'b0;
        end else if (apply && ok && op == OP_SET_MST) begin
            mst_q <= 1'b1;
        end
    end

    assign lock_vec    = lock_q;
    assign master_lock = mst_q;
endmodule

// File: rtl/lock_cmd_fsm.sv
module lock_cmd_fsm
    import flash_lock_pkg::*;
#(
    parameter int NBLK = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_cmd,
    input  logic [$clog2(NBLK)-1:0] wr_blk,
    input  logic                    timer_done,
    input  lk_err_t                 op_err,
    output logic                    timer_load,
    output logic                    apply,
    output lk_op_e                  op,
    output logic [$clog2(NBLK)-1:0] op_blk,
    output logic                    ready,
    output logic                    status_mode,
    output logic [7:0]              status
);
    localparam int BLK_W = $clog2(NBLK);

    lk_state_e        state_q, state_d;
    lk_op_e           op_q, op_d;
    logic [BLK_W-1:0] blk_q, blk_d;
    lk_err_t          err_q;
    logic             inval;
    logic             clr_stat;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARRAY;
            op_q    <= OP_NONE;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            blk_q   <= blk_d;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        op_d       = op_q;
        blk_d      = blk_q;
        timer_load = 1'b0;
        inval      = 1'b0;
        clr_stat   = 1'b0;
        unique case (state_q)
            ST_ARRAY, ST_STATUS: begin
                if (wr_en) begin
                    case (wr_cmd)
                        CMD_SETUP:    state_d  = ST_SETUP;
                        CMD_RD_STAT:  state_d  = ST_STATUS;
                        CMD_RD_ARR:   state_d  = ST_ARRAY;
                        CMD_CLR_STAT: clr_stat = 1'b1;
                        default:      ;
                    endcase
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    state_d    = ST_BUSY;
                    timer_load = 1'b1;
                    blk_d      = wr_blk;
                    case (wr_cmd)
                        CMD_CF_BLK: op_d = OP_SET_BLK;
                        CMD_CF_MST: op_d = OP_SET_MST;
                        CMD_CF_CLR: op_d = OP_CLR;
                        default: begin
                            state_d    = ST_STATUS;
                            timer_load = 1'b0;
                            inval      = 1'b1;
                        end
                    endcase
                end
            end
            ST_BUSY: begin
                if (timer_done) state_d = ST_STATUS;
            end
        endcase
    end

    // Sticky error bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (clr_stat) begin
            err_q <= '0;
        end else if (inval) begin
            err_q.set <= 1'b1;
            err_q.clr <= 1'b1;
        end else if (apply) begin
            err_q <= lk_err_t'(err_q | op_err);
        end
    end

    // Outputs
    always_comb begin
        ready       = (state_q != ST_BUSY);
        status_mode = (state_q != ST_ARRAY);
        apply       = (state_q == ST_BUSY) && timer_done;
        op          = op_q;
        op_blk      = blk_q;
        status      = {ready, 1'b0, err_q.clr, err_q.set, err_q.vpp,
                       1'b0, err_q.prot, 1'b0};
    end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int NBLK     = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_cmd,
    input  logic [$clog2(NBLK)-1:0] wr_blk,
    input  logic                    hv_ovr,
    input  logic                    vpp_ok,
    output logic                    ready,
    output logic                    status_mode,
    output logic [7:0]              status,
    output logic [NBLK-1:0]         lock_vec,
    output logic                    master_lock
);
    localparam int BLK_W = $clog2(NBLK);

    logic             t_load;
    logic             t_done;
    logic             apply;
    lk_op_e           op;
    logic [BLK_W-1:0] op_blk;
    lk_err_t          op_err;

    lock_cmd_fsm #(.NBLK(NBLK)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_cmd     (wr_cmd),
        .wr_blk     (wr_blk),
        .timer_done (t_done),
        .op_err     (op_err),
        .timer_load (t_load),
        .apply      (apply),
        .op         (op),
        .op_blk     (op_blk),
        .ready      (ready),
        .status_mode(status_mode),
        .status     (status)
    );

    lock_busy_timer #(.CYCLES(BUSY_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (t_load),
        .done (t_done)
    );

    lock_bit_store #(.NBLK(NBLK)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply      (apply),
        .op         (op),
        .blk        (op_blk),
        .hv_ovr     (hv_ovr),
        .vpp_ok     (vpp_ok),
        .err        (op_err),
        .lock_vec   (lock_vec),
        .master_lock(master_lock)
    );
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
    parameter int NBLK     = 16,
    parameter int BUSY_CYC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      wr_cmd,
    input logic            vpp_ok,
    input logic            ready,
    input logic [1:0]      err_hi,
    input logic [NBLK-1:0] lock_vec,
    input logic            master_lock
);
    logic [31:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!ready) low_cnt <= low_cnt + 32'd1;
        else             low_cnt <= '0;
    end

    // R10
    master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        master_lock |=> master_lock);

    // R8
    vpp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_ok |=> ($stable(lock_vec) && $stable(master_lock)));

    // R3
    lock_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(lock_vec) && $stable(master_lock)) |-> ($past(!ready) && ready));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cnt == 32'(BUSY_CYC)));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hi[0] && !(wr_en && wr_cmd == 8'h50)) |=> err_hi[0]);
endmodule

bind flash_lock_ctrl flash_lock_chk #(.NBLK(NBLK), .BUSY_CYC(BUSY_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_cmd     (wr_cmd),
    .vpp_ok     (vpp_ok),
    .ready      (ready),
    .err_hi     (status[5:4]),
    .lock_vec   (lock_vec),
    .master_lock(master_lock)
);

// File: tb/flash_lock_ctrl_tb_top.sv
module flash_lock_ctrl_tb_top;
    localparam int NBLK = 16;
    localparam int BUSY = 8;
    localparam int BW   = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n, wr_en, hv_ovr, vpp_ok;
    logic [7:0]      wr_cmd;
    logic [BW-1:0]   wr_blk;
    logic            ready, status_mode, master_lock;
    logic [7:0]      status;
    logic [NBLK-1:0] lock_vec;

    flash_lock_ctrl #(.NBLK(NBLK), .BUSY_CYC(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_blk(wr_blk),
        .hv_ovr(hv_ovr), .vpp_ok(vpp_ok), .ready(ready), .status_mode(status_mode),
        .status(status), .lock_vec(lock_vec), .master_lock(master_lock)
    );

    typedef struct {
        string           req;
        logic [7:0]      st;
        logic [NBLK-1:0] lk;
        logic            ms;
        logic            sm;
    } exp_t;

    exp_t sb_q[$];
    event smp_ev;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    logic [NBLK-1:0] m_lock;
    logic            m_mst, m_rdy, m_sm;
    logic [7:0]      m_err;

    task automatic chk(input string req);
        exp_t e;
        e.req = req;
        e.st  = (m_rdy ? 8'h80 : 8'h00) | m_err;
        e.lk  = m_lock;
        e.ms  = m_mst;
        e.sm  = m_sm;
        sb_q.push_back(e);
        ->smp_ev;
    endtask

    // Monitor: compares design outputs against queued expectations
    initial begin : mon
        exp_t e;
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                n_chk++;
                if (status !== e.st || lock_vec !== e.lk || master_lock !== e.ms ||
                    status_mode !== e.sm || ready !== e.st[7]) begin
                    n_fail++;
                    $display("FAIL %s: status=%h lock=%h mst=%b mode=%b rdy=%b exp status=%h lock=%h mst=%b mode=%b",
                             e.req, status, lock_vec, master_lock, status_mode, ready,
                             e.st, e.lk, e.ms, e.sm);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] c, input logic [BW-1:0] b);
        wr_en  = 1'b1;
        wr_cmd = c;
        wr_blk = b;
        @(negedge clk);
        wr_en  = 1'b0;
        wr_cmd = 8'h00;
    endtask

    task automatic model_apply(input logic [7:0] conf, input logic [BW-1:0] b);
        case (conf)
            8'h01: if (!vpp_ok) m_err |= 8'h18;
                   else if (m_mst && !hv_ovr) m_err |= 8'h12;
                   else m_lock[b] = 1'b1;
            8'hF1: if (!vpp_ok) m_err |= 8'h18;
                   else if (!hv_ovr) m_err |= 8'h12;
                   else m_mst = 1'b1;
            8'hD0: if (!vpp_ok) m_err |= 8'h28;
                   else if (m_mst && !hv_ovr) m_err |= 8'h22;
                   else m_lock = '0;
            default: ;
        endcase
    endtask

    // Setup + confirm, optional ignored writes while busy, then completion
    task automatic lock_op(input logic [7:0] conf, input logic [BW-1:0] b,
                           input int junk, input string req);
        wr(8'h60, ~b);
        m_sm = 1'b1;
        wr(conf, b);
        m_rdy = 1'b0;
        chk("R3 busy start");
        for (int i = 0; i < junk; i++) begin
            wr((i == 0) ? 8'hFF : (i == 1) ? 8'h50 : 8'h60, b);  // R4
        end
        repeat (BUSY - 1 - junk) @(negedge clk);
        chk(junk > 0 ? "R4 busy end" : "R3 busy end");
        @(negedge clk);
        m_rdy = 1'b1;
        model_apply(conf, b);
        chk(req);
    endtask

    task automatic clr_status();
        wr(8'h50, '0);
        m_err = 8'h00;
        chk("R11 clear");
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_cmd = 8'h00; wr_blk = '0;
        hv_ovr = 1'b0; vpp_ok = 1'b1;
        m_lock = '0; m_mst = 1'b0; m_rdy = 1'b1; m_sm = 1'b0; m_err = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset");

        wr(8'h50, '0);          chk("R12 clear in array");
        lock_op(8'h01, 4'd3, 0, "R2 set blk 3");
        lock_op(8'h01, 4'd12, 0, "R2 set blk 12");
        wr(8'hFF, '0); m_sm = 1'b0; chk("R12 array");
        wr(8'h70, '0); m_sm = 1'b1; chk("R12 status");
        lock_op(8'hD0, 4'd0, 0, "R7 clear all");
        lock_op(8'hF1, 4'd9, 0, "R5 master no hv");
        lock_op(8'h01, 4'd5, 3, "R11 run with errors");
        clr_status();
        hv_ovr = 1'b1;
        lock_op(8'hF1, 4'd0, 0, "R5 master with hv");
        hv_ovr = 1'b0;
        lock_op(8'h01, 4'd7, 0, "R6 blk no hv");
        clr_status();
        hv_ovr = 1'b1;
        lock_op(8'h01, 4'd7, 0, "R6 blk with hv");
        hv_ovr = 1'b0;
        lock_op(8'hD0, 4'd0, 0, "R7 clear blocked");
        clr_status();
        hv_ovr = 1'b1;
        lock_op(8'hD0, 4'd0, 0, "R10 master kept");
        lock_op(8'h01, 4'd2, 0, "R6 blk 2");
        vpp_ok = 1'b0;
        lock_op(8'h01, 4'd9, 0, "R8 set low vpp");
        clr_status();
        lock_op(8'hD0, 4'd0, 0, "R8 clear low vpp");
        vpp_ok = 1'b1;
        clr_status();
        wr(8'h60, '0); m_sm = 1'b1; chk("R9 setup");
        wr(8'h33, 4'd6); m_err |= 8'h30; chk("R9 invalid confirm");
        clr_status();
        #1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: act=timeout exp=completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule